// File: doc/BRIEF.md
# MDIO Management Command Engine

This engine runs one Clause-22 management transaction at a time to an external PHY. Software sets it up through a small 16-bit register port. For a write, software first loads the data word into the write-data register. It then writes the command word, which holds the opcode bits, the PHY address and the register number. The engine builds the serial frame and shifts it out on MDC/MDIO. A read clears its read bit only after the 16 returned bits have been placed in the read-data register.

MDC is produced by dividing the system clock. Each half period of MDC lasts `DIV` system clocks, and MDC rests low between transactions. The engine changes MDIO only on the falling edge of MDC. It samples returned data on the rising edge. During a read it stops driving the line from the turnaround onward. The board pulls the line high, so a PHY that never answers yields all ones.

Register map:
- Address 0 is the command word.
- Address 1 is write data.
- Address 2 is read data.
- Address 3 reads as zero.

A read strobe returns the selected register on `reg_rdata` one clock later, and the value is held until the next strobe.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command, write-data and read-data registers all read 0, MDC is low and MDIO is not driven.
- R2: Writing address 0 with bit 14 set starts a write. Bits 12:8 give the PHY address and bits 4:0 the register number. The frame leaves MSB first, one bit per MDC period, with MDIO driven for all 64 bits. In order it holds 32 ones, start 01, opcode 01, the 5 address bits, the 5 register bits, turnaround 10 and the 16 bits of the write-data register.
- R3: Bit 13 set with bit 14 clear starts a read. The read frame uses opcode 10, and the engine releases MDIO for the last 18 bits (turnaround and data). It places the 16 bits sampled on the MDC rising edges, MSB first, into the read-data register.
- R4: While a transaction runs, the command word reads back its opcode bit (14 or 13) set along with the PHY address and register number. The bit clears by itself once the last bit period ends.
- R5: MDC is low whenever the engine is idle. While active, MDC has a period of 2·DIV system clocks. A driven MDIO changes only on a falling edge of MDC.
- R6: A read addressed to a PHY that does not answer returns 0xFFFF.
- R7: A command written while a transaction runs is ignored. The running frame, the latched address fields and the read-data register are unaffected.
- R8: The write-data register reads back what was written, and a write transaction leaves the read-data register unchanged.
- R9: A command with both bit 14 and bit 13 set performs a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | AW | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, valid one clock after the strobe |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench builds the engine with DIV = 3. This gives an odd divider count and a frame of only 384 system clocks, so that many full transactions fit in the run. It is short enough that the bench can overlap a second command with a running one. It can also measure the MDC period directly. A bench PHY model answers at a single address. It drives its response from MDC falling edges, which exercises the release at turnaround, the MSB-first assembly and the 0xFFFF result from an unanswered address.

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine #(
  parameter int DIV = 8,
  parameter int AW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i
);
  localparam int CW        = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int LAST_BIT  = 63;
  localparam int TA_BIT    = 46;
  localparam int DATA_BIT  = 48;

  logic [15:0] wdata_q, rdata_q, rx_q;
  logic [4:0]  phy_q, regn_q;
  logic        wr_busy, rd_busy;
  logic [63:0] sh;
  logic [5:0]  idx;
  logic [CW-1:0] div_cnt;
  logic        mdc_q;

  wire busy     = wr_busy | rd_busy;
  wire tick     = busy && (div_cnt == CW'(DIV - 1));
  wire cmd_wr   = reg_wr && (reg_addr == AW'(0));
  wire start_wr = cmd_wr && !busy && reg_wdata[14];
  wire start_rd = cmd_wr && !busy && !reg_wdata[14] && reg_wdata[13];

  assign mdc     = mdc_q;
  assign mdio_o  = sh[63];
  assign mdio_oe = wr_busy || (rd_busy && idx < 6'(TA_BIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0; rdata_q <= '0; rx_q <= '0;
      phy_q <= '0; regn_q <= '0;
      wr_busy <= 1'b0; rd_busy <= 1'b0;
      sh <= '0; idx <= '0; div_cnt <= '0; mdc_q <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == AW'(1)) wdata_q <= reg_wdata;
      if (start_wr || start_rd) begin
        phy_q   <= reg_wdata[12:8];
        regn_q  <= reg_wdata[4:0];
        wr_busy <= start_wr;
        rd_busy <= start_rd;
        sh      <= {32'hFFFF_FFFF, 2'b01, start_rd ? 2'b10 : 2'b01,
                    reg_wdata[12:8], reg_wdata[4:0], 2'b10, wdata_q};
        idx     <= '0;
        div_cnt <= '0;
        mdc_q   <= 1'b0;
      end else if (busy) begin
        div_cnt <= tick ? '0 : div_cnt + 1'b1;
        if (tick) begin
          if (!mdc_q) begin
            mdc_q <= 1'b1;
            if (rd_busy && idx >= 6'(DATA_BIT)) rx_q <= {rx_q[14:0], mdio_i};
          end else begin
            mdc_q <= 1'b0;
            if (idx == 6'(LAST_BIT)) begin
              wr_busy <= 1'b0;
              rd_busy <= 1'b0;
              if (rd_busy) rdata_q <= rx_q;
            end else begin
              idx <= idx + 1'b1;
              sh  <= {sh[62:0], 1'b0};
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        AW'(0):  reg_rdata <= {1'b0, wr_busy, rd_busy, phy_q, 3'b000, regn_q};
        AW'(1):  reg_rdata <= wdata_q;
        AW'(2):  reg_rdata <= rdata_q;
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

module mdio_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       wr_busy,
  input logic       rd_busy,
  input logic [5:0] idx
);
  a_r5_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_busy || rd_busy) |-> !mdc);

  a_r5_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));

  a_r4_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_busy, rd_busy}));

  a_r3_release_ta: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && idx >= 6'd46) |-> !mdio_oe);

  a_r2_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> mdio_oe);
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .wr_busy(wr_busy), .rd_busy(rd_busy), .idx(idx)
);

// File: tb/mdio_cmd_engine_test.sv
module mdio_cmd_engine_test;
  localparam int DIV = 3;
  localparam logic [4:0] PHY_AT = 5'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [63:0] cap, oe_cap;
  int nrise = 0;
  logic phy_drv = 1'b0, phy_bit = 1'b1;
  logic [15:0] phy_regs [32];

  always #10 clk = ~clk;
  assign mdio_i = phy_drv ? phy_bit : 1'b1;

  mdio_cmd_engine #(.DIV(DIV), .AW(2)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc) begin
    if (nrise < 64) begin
      cap[63 - nrise]    = mdio_o;
      oe_cap[63 - nrise] = mdio_oe;
    end
    nrise = nrise + 1;
  end

  always @(negedge mdc) begin
    if (nrise >= 47 && nrise <= 63 && cap[29:28] == 2'b10 && cap[27:23] == PHY_AT) begin
      phy_drv = 1'b1;
      phy_bit = (nrise == 47) ? 1'b0 : phy_regs[cap[22:18]][63 - nrise];
    end else begin
      phy_drv = 1'b0;
    end
  end

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic start_cmd(input logic [15:0] c);
    nrise = 0; cap = '0; oe_cap = '0;
    bus_wr(2'd0, c);
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 2000; i++) begin
      bus_rd(2'd0, v);
      if (v[14:13] == 2'b00) return;
    end
    check("R4 busy never cleared", 1, 0);
  endtask

  function automatic logic [63:0] frame(input logic [1:0] op, input logic [4:0] p,
                                        input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, op, p, r, 2'b10, d};
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    check("R1 mdc low", mdc, 0);
    check("R1 oe low", mdio_oe, 0);
    bus_rd(2'd0, v); check("R1 cmd reg", v, 0);
    bus_rd(2'd1, v); check("R1 wdata reg", v, 0);
    bus_rd(2'd2, v); check("R1 rdata reg", v, 0);
  endtask

  task automatic t_write();
    logic [15:0] v;
    bus_wr(2'd1, 16'hA5C3);
    bus_rd(2'd1, v); check("R8 wdata readback", v, 16'hA5C3);
    start_cmd(16'h4000 | (16'(PHY_AT) << 8) | 16'd9);
    bus_rd(2'd0, v); check("R4 busy readback", v, 16'h4309);
    wait_idle();
    check("R2 write frame", cap, frame(2'b01, PHY_AT, 5'd9, 16'hA5C3));
    check("R2 driven all bits", oe_cap, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_rd(2'd2, v); check("R8 rdata untouched by write", v, 0);
    check("R5 mdc low after", mdc, 0);
  endtask

  task automatic t_read(input logic [4:0] r, input logic [15:0] d);
    logic [15:0] v;
    phy_regs[r] = d;
    start_cmd(16'h2000 | (16'(PHY_AT) << 8) | 16'(r));
    bus_rd(2'd0, v); check("R4 read busy readback", v, 16'h2000 | (16'(PHY_AT) << 8) | 16'(r));
    wait_idle();
    bus_rd(2'd2, v); check("R3 read data", v, d);
    check("R3 read header", cap[63:18], frame(2'b10, PHY_AT, r, 16'h0) >> 18);
    check("R3 released ta+data", oe_cap[17:0], 0);
  endtask

  task automatic t_absent();
    logic [15:0] v;
    start_cmd(16'h2000 | (16'd7 << 8) | 16'd2);
    wait_idle();
    bus_rd(2'd2, v); check("R6 absent phy", v, 16'hFFFF);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] v;
    bus_wr(2'd1, 16'h0F0F);
    start_cmd(16'h4000 | (16'(PHY_AT) << 8) | 16'd1);
    repeat (20) @(negedge clk);
    bus_wr(2'd0, 16'h2000 | (16'd5 << 8) | 16'd17);
    bus_rd(2'd0, v); check("R7 fields kept", v, 16'h4301);
    wait_idle();
    check("R7 frame unchanged", cap, frame(2'b01, PHY_AT, 5'd1, 16'h0F0F));
    bus_rd(2'd2, v); check("R7 rdata unchanged", v, 16'hFFFF);
  endtask

  task automatic t_both();
    logic [15:0] v;
    start_cmd(16'h6000 | (16'(PHY_AT) << 8) | 16'd17);
    wait_idle();
    check("R9 both bits writes", cap[29:28], 2'b01);
    bus_rd(2'd2, v); check("R9 rdata unchanged", v, 16'hFFFF);
  endtask

  task automatic t_period();
    realtime t0, t1;
    start_cmd(16'h2000 | (16'(PHY_AT) << 8) | 16'd4);
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    check("R5 mdc period", 64'(int'(t1 - t0)), 64'(2 * DIV * 20));
    wait_idle();
    check("R5 mdc idle low", mdc, 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) phy_regs[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read(5'd17, 16'h1234);
    t_read(5'd30, 16'h8001);
    t_absent();
    t_busy_ignore();
    t_both();
    t_period();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule